// File: doc/BRIEF.md
# Clustered Mesh Route Switch

This block is the switch that one cluster of four compute cells shares inside a concentrated mesh network. It has three classes of 36-bit ports, each four lanes wide: the local lanes that face the cluster's own cells, the horizontal lanes that link to the neighbouring cluster along the row, and the vertical lanes that link to the neighbouring cluster along the column. Each of the twelve outputs picks one of the twelve inputs. The choice comes from a static per-cycle configuration word, which is assembled from the network-control bits of the cells' instruction codes. The switch has no headers and no arbitration between packets.

The switch enforces dimension-order routing. A word finishes its horizontal travel before it turns vertical, so a vertical input can never be steered onto a horizontal output. Any configuration that asks for that turn, or that names a source index outside the twelve real ones, is rejected. The output it addresses drives invalid and raises an error bit. Every output is registered once, so each hop costs exactly one cycle. A higher-level tier is built from the same module: its local lanes connect to four lower-level switches.

Top module: `cmesh_route_switch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output valid bit, every output data word and every error bit is zero.
- R2: The configuration word holds one 5-bit field per output. Output k uses bits [5k+4:5k]. Outputs 0-3 are local lanes 0-3, outputs 4-7 are horizontal lanes 0-3 and outputs 8-11 are vertical lanes 0-3. Bit 4 of a field is the enable and bits 3:0 are the source index. A source index of 0-3 selects a local input lane, 4-7 selects a horizontal input lane and 8-11 selects a vertical input lane. An enabled, legal field delivers that source's data and valid bit on the output one clock edge later.
- R3: An output whose field has the enable bit clear drives valid 0, data 0 and error 0, whatever its source index is.
- R4: A horizontal output (4-7) whose enabled field selects a vertical source (8-11) breaks X-then-Y ordering. It drives valid 0 and data 0, and it sets its error bit.
- R5: An enabled field with a source index of 12-15 is rejected on any output. The output drives valid 0 and data 0, and it sets its error bit.
- R6: Local and vertical outputs accept all twelve source indices 0-11.
- R7: One source may feed any number of outputs in the same cycle.
- R8: The summary error output is 1 exactly when at least one per-output error bit is 1 in the same cycle.
- R9: An output drives the valid bit of its selected source. When that bit is 0, its data is 0.
- R10: A change on the inputs or the configuration has no effect on the outputs before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_in_data | input | 144 | Local input lanes, lane l at bits [36l+35:36l] |
| loc_in_valid | input | 4 | Local input valid bits |
| hor_in_data | input | 144 | Horizontal input lanes |
| hor_in_valid | input | 4 | Horizontal input valid bits |
| ver_in_data | input | 144 | Vertical input lanes |
| ver_in_valid | input | 4 | Vertical input valid bits |
| route_cfg | input | 60 | Twelve 5-bit route fields, one per output |
| loc_out_data | output | 144 | Local output lanes (outputs 0-3) |
| loc_out_valid | output | 4 | Local output valid bits |
| hor_out_data | output | 144 | Horizontal output lanes (outputs 4-7) |
| hor_out_valid | output | 4 | Horizontal output valid bits |
| ver_out_data | output | 144 | Vertical output lanes (outputs 8-11) |
| ver_out_valid | output | 4 | Vertical output valid bits |
| route_err | output | 12 | Per-output rejected-route flags |
| route_err_any | output | 1 | OR of all rejected-route flags |

## Verification
The switch holds no state other than its output registers, so a wrong decode or mux selection shows up at the ports on the very next clock edge after the offending configuration. It appears as the wrong lane's pattern, a valid bit that should have been masked, or an error bit out of step with the ordering rule. The bench sweeps every output against every source index with the enable both set and clear. Each input lane carries a distinct data pattern, so any misrouting appears as a wrong tag on the output. Further checks cover valid masking, fan-out, reset and the one-edge latency.

// File: rtl/cmesh_sw_pkg.sv
package cmesh_sw_pkg;

    typedef enum logic [1:0] {
        CLS_LOCAL = 2'd0,
        CLS_HORZ  = 2'd1,
        CLS_VERT  = 2'd2,
        CLS_NONE  = 2'd3
    } port_cls_e;

    // Port class of a flat index; lanes per class given by 'lanes'.
    function automatic port_cls_e cls_of(input int idx, input int lanes);
        if (idx < lanes)          return CLS_LOCAL;
        else if (idx < 2 * lanes) return CLS_HORZ;
        else if (idx < 3 * lanes) return CLS_VERT;
        else                      return CLS_NONE;
    endfunction

    // X-then-Y: once a word has travelled vertically it may not turn back
    // onto a horizontal link. Unknown sources are never legal.
    function automatic logic turn_legal(input port_cls_e dst, input port_cls_e src);
        if (src == CLS_NONE)                       return 1'b0;
        if (dst == CLS_HORZ && src == CLS_VERT)    return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/cmesh_route_decode.sv
module cmesh_route_decode
    import cmesh_sw_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int OUT_IDX = 0,
    parameter int SEL_W   = 4
) (
    input  logic [SEL_W:0]   field_i,
    output logic [SEL_W-1:0] src_sel_o,
    output logic             route_ok_o,
    output logic             route_err_o
);
    localparam port_cls_e DST_CLS = cls_of(OUT_IDX, LANES);

    logic       enable;
    logic       legal;
    port_cls_e  src_cls;

    always_comb begin
        enable      = field_i[SEL_W];
        src_sel_o   = field_i[SEL_W-1:0];
        src_cls     = cls_of(int'(src_sel_o), LANES);
        legal       = turn_legal(DST_CLS, src_cls);
        route_ok_o  = enable && legal;
        route_err_o = enable && !legal;
    end

endmodule

// File: rtl/cmesh_src_mux.sv
module cmesh_src_mux #(
    parameter int DATA_W  = 36,
    parameter int NUM_SRC = 12,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_SRC*DATA_W-1:0] src_data_i,
    input  logic [NUM_SRC-1:0]        src_valid_i,
    input  logic [SEL_W-1:0]          sel_i,
    input  logic                      enable_i,
    output logic [DATA_W-1:0]         data_o,
    output logic                      valid_o
);
    always_comb begin
        data_o  = '0;
        valid_o = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (enable_i && sel_i == SEL_W'(i)) begin
                valid_o = src_valid_i[i];
                data_o  = src_data_i[i*DATA_W +: DATA_W];
            end
        end
        if (!valid_o) data_o = '0;
    end

endmodule

// File: rtl/cmesh_route_switch.sv
module cmesh_route_switch #(
    parameter int DATA_W = 36,
    parameter int LANES  = 4,
    localparam int NUM_PORT = 3 * LANES,
    localparam int SEL_W    = $clog2(NUM_PORT),
    localparam int FIELD_W  = SEL_W + 1,
    localparam int CFG_W    = NUM_PORT * FIELD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*DATA_W-1:0] loc_in_data,
    input  logic [LANES-1:0]        loc_in_valid,
    input  logic [LANES*DATA_W-1:0] hor_in_data,
    input  logic [LANES-1:0]        hor_in_valid,
    input  logic [LANES*DATA_W-1:0] ver_in_data,
    input  logic [LANES-1:0]        ver_in_valid,
    input  logic [CFG_W-1:0]        route_cfg,
    output logic [LANES*DATA_W-1:0] loc_out_data,
    output logic [LANES-1:0]        loc_out_valid,
    output logic [LANES*DATA_W-1:0] hor_out_data,
    output logic [LANES-1:0]        hor_out_valid,
    output logic [LANES*DATA_W-1:0] ver_out_data,
    output logic [LANES-1:0]        ver_out_valid,
    output logic [NUM_PORT-1:0]     route_err,
    output logic                    route_err_any
);

    typedef struct packed {
        logic [NUM_PORT-1:0][DATA_W-1:0] data;
        logic [NUM_PORT-1:0]             valid;
        logic [NUM_PORT-1:0]             err;
        logic                            err_any;
    } sw_state_t;

    sw_state_t state_d, state_q;

    // Flat source bus: local lanes at 0.., horizontal next, vertical last.
    logic [NUM_PORT*DATA_W-1:0] src_data;
    logic [NUM_PORT-1:0]        src_valid;

    assign src_data  = {ver_in_data, hor_in_data, loc_in_data};
    assign src_valid = {ver_in_valid, hor_in_valid, loc_in_valid};

    logic [NUM_PORT-1:0][DATA_W-1:0] mux_data;
    logic [NUM_PORT-1:0]             mux_valid;
    logic [NUM_PORT-1:0]             dec_err;

    for (genvar k = 0; k < NUM_PORT; k++) begin : g_out
        logic [SEL_W-1:0] sel;
        logic             ok;

        cmesh_route_decode #(
            .LANES   (LANES),
            .OUT_IDX (k),
            .SEL_W   (SEL_W)
        ) u_dec (
            .field_i     (route_cfg[k*FIELD_W +: FIELD_W]),
            .src_sel_o   (sel),
            .route_ok_o  (ok),
            .route_err_o (dec_err[k])
        );

        cmesh_src_mux #(
            .DATA_W  (DATA_W),
            .NUM_SRC (NUM_PORT),
            .SEL_W   (SEL_W)
        ) u_mux (
            .src_data_i  (src_data),
            .src_valid_i (src_valid),
            .sel_i       (sel),
            .enable_i    (ok),
            .data_o      (mux_data[k]),
            .valid_o     (mux_valid[k])
        );
    end

    always_comb begin
        state_d         = state_q;
        state_d.data    = mux_data;
        state_d.valid   = mux_valid;
        state_d.err     = dec_err;
        state_d.err_any = |dec_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_pins
        assign loc_out_data[l*DATA_W +: DATA_W] = state_q.data[l];
        assign hor_out_data[l*DATA_W +: DATA_W] = state_q.data[LANES + l];
        assign ver_out_data[l*DATA_W +: DATA_W] = state_q.data[2*LANES + l];
        assign loc_out_valid[l] = state_q.valid[l];
        assign hor_out_valid[l] = state_q.valid[LANES + l];
        assign ver_out_valid[l] = state_q.valid[2*LANES + l];
    end

    assign route_err     = state_q.err;
    assign route_err_any = state_q.err_any;

    // ---------------- assertions ----------------
    assert_err_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        route_err_any == (|route_err));

    for (genvar k = 0; k < NUM_PORT; k++) begin : g_chk
        assert_err_blocks_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
            route_err[k] |-> !state_q.valid[k]);

        assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !state_q.valid[k] |-> (state_q.data[k] == '0));

        assert_valid_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
            state_q.valid[k] |-> $past(route_cfg[k*FIELD_W + SEL_W]));

        if (k >= LANES && k < 2 * LANES) begin : g_hor
            assert_no_y_to_x_turn_R4: assert property (@(posedge clk) disable iff (!rst_n)
                state_q.valid[k] |->
                    ($past(route_cfg[k*FIELD_W +: SEL_W]) < SEL_W'(2 * LANES)));
        end
    end

endmodule

// File: tb/cmesh_route_switch_test.sv
`timescale 1ns/1ps
module cmesh_route_switch_test;

    localparam int DW    = 36;
    localparam int LN    = 4;
    localparam int NP    = 3 * LN;
    localparam int SW    = 4;
    localparam int FW    = SW + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LN*DW-1:0]  loc_in_data = '0, hor_in_data = '0, ver_in_data = '0;
    logic [LN-1:0]     loc_in_valid = '0, hor_in_valid = '0, ver_in_valid = '0;
    logic [NP*FW-1:0]  route_cfg = '0;
    logic [LN*DW-1:0]  loc_out_data, hor_out_data, ver_out_data;
    logic [LN-1:0]     loc_out_valid, hor_out_valid, ver_out_valid;
    logic [NP-1:0]     route_err;
    logic              route_err_any;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cmesh_route_switch uut (
        .clk(clk), .rst_n(rst_n),
        .loc_in_data(loc_in_data), .loc_in_valid(loc_in_valid),
        .hor_in_data(hor_in_data), .hor_in_valid(hor_in_valid),
        .ver_in_data(ver_in_data), .ver_in_valid(ver_in_valid),
        .route_cfg(route_cfg),
        .loc_out_data(loc_out_data), .loc_out_valid(loc_out_valid),
        .hor_out_data(hor_out_data), .hor_out_valid(hor_out_valid),
        .ver_out_data(ver_out_data), .ver_out_valid(ver_out_valid),
        .route_err(route_err), .route_err_any(route_err_any)
    );

    function automatic logic [DW-1:0] pat(input int s, input logic [31:0] seed);
        return {4'(s), seed + 32'(s) * 32'h0001_1111};
    endfunction

    function automatic logic [DW-1:0] out_data(input int k);
        if (k < LN)          return loc_out_data[k*DW +: DW];
        else if (k < 2 * LN) return hor_out_data[(k-LN)*DW +: DW];
        else                 return ver_out_data[(k-2*LN)*DW +: DW];
    endfunction

    function automatic logic out_valid(input int k);
        if (k < LN)          return loc_out_valid[k];
        else if (k < 2 * LN) return hor_out_valid[k-LN];
        else                 return ver_out_valid[k-2*LN];
    endfunction

    // Legality from the requirements: index 0-11 only, no vertical->horizontal.
    function automatic logic legal(input int k, input int s);
        if (s >= NP) return 1'b0;
        if (k >= LN && k < 2 * LN && s >= 2 * LN) return 1'b0;
        return 1'b1;
    endfunction

    task automatic drive_inputs(input logic [31:0] seed, input logic [NP-1:0] vmask);
        for (int s = 0; s < NP; s++) begin
            if (s < LN) begin
                loc_in_data[s*DW +: DW] = pat(s, seed);
                loc_in_valid[s] = vmask[s];
            end else if (s < 2 * LN) begin
                hor_in_data[(s-LN)*DW +: DW] = pat(s, seed);
                hor_in_valid[s-LN] = vmask[s];
            end else begin
                ver_in_data[(s-2*LN)*DW +: DW] = pat(s, seed);
                ver_in_valid[s-2*LN] = vmask[s];
            end
        end
    endtask

    task automatic set_field(input int k, input logic en, input int s);
        route_cfg[k*FW +: FW] = {en, 4'(s)};
    endtask

    task automatic check_port(input int k, input logic ev, input logic [DW-1:0] ed,
                              input logic ee, input string tag);
        checks++;
        if (out_valid(k) !== ev || out_data(k) !== ed || route_err[k] !== ee) begin
            failures++;
            $display("FAIL %s out%0d: valid=%0b data=%h err=%0b expected valid=%0b data=%h err=%0b",
                     tag, k, out_valid(k), out_data(k), route_err[k], ev, ed, ee);
        end
    endtask

    task automatic check_any(input logic e, input string tag);
        checks++;
        if (route_err_any !== e) begin
            failures++;
            $display("FAIL %s err_any=%0b expected %0b", tag, route_err_any, e);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset holds outputs clear even with live config and inputs
        @(negedge clk);
        drive_inputs(32'hA0A0_0000, '1);
        for (int k = 0; k < NP; k++) set_field(k, 1'b1, (k + 7) % 16);
        tick();
        for (int k = 0; k < NP; k++) check_port(k, 1'b0, '0, 1'b0, "R1");
        check_any(1'b0, "R1");
        @(negedge clk);
        route_cfg = '0;
        rst_n = 1'b1;
        tick();
        for (int k = 0; k < NP; k++) check_port(k, 1'b0, '0, 1'b0, "R1");

        // R2/R3/R4/R5/R6/R8: exhaustive output x source x enable sweep
        for (int k = 0; k < NP; k++) begin
            for (int s = 0; s < 16; s++) begin
                for (int en = 0; en < 2; en++) begin
                    logic ok, ev, ee;
                    logic [31:0] seed;
                    string tag;
                    seed = 32'(k * 64 + s * 2 + en) * 32'h0101_0007;
                    @(negedge clk);
                    route_cfg = '0;
                    set_field(k, en[0], s);
                    drive_inputs(seed, '1);
                    tick();
                    ok = legal(k, s);
                    ev = en[0] && ok;
                    ee = en[0] && !ok;
                    if (en == 0)                          tag = "R3";
                    else if (s >= NP)                     tag = "R5";
                    else if (!ok)                         tag = "R4";
                    else if (k < LN || k >= 2 * LN)       tag = "R6";
                    else                                  tag = "R2";
                    check_port(k, ev, ev ? pat(s, seed) : '0, ee, tag);
                    check_any(ee, "R8");
                    check_port((k + 1) % NP, 1'b0, '0, 1'b0, "R3");
                end
            end
        end

        // R9: identity routing with a sparse valid mask
        @(negedge clk);
        for (int k = 0; k < NP; k++) set_field(k, 1'b1, k);
        drive_inputs(32'h5555_0000, 12'hA5A);
        tick();
        for (int k = 0; k < NP; k++)
            check_port(k, 12'hA5A >> k & 1, (12'hA5A >> k & 1) ? pat(k, 32'h5555_0000) : '0,
                       1'b0, "R9");

        // R7: one horizontal source fanned out to all twelve outputs
        @(negedge clk);
        for (int k = 0; k < NP; k++) set_field(k, 1'b1, 5);
        drive_inputs(32'h7777_1234, '1);
        tick();
        for (int k = 0; k < NP; k++) check_port(k, 1'b1, pat(5, 32'h7777_1234), 1'b0, "R7");
        check_any(1'b0, "R7");

        // R10: outputs hold until the next rising edge
        @(negedge clk);
        route_cfg = '0;
        drive_inputs(32'h0BAD_0000, '0);
        #1;
        for (int k = 0; k < NP; k++) check_port(k, 1'b1, pat(5, 32'h7777_1234), 1'b0, "R10");
        tick();
        for (int k = 0; k < NP; k++) check_port(k, 1'b0, '0, 1'b0, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule